// File: doc/BRIEF.md
# Converter Result Byte-Pair Register with Read Interlock

This block keeps the most recent 10-bit conversion result and presents it to an 8-bit processor bus as a pair of bytes, a lower byte and an upper byte. One control bit chooses how the 10 bits sit in the 16-bit pair. In right justification the result fills the pair from bit 0 upward. In left justification it fills the pair from bit 15 downward, so that the upper byte alone holds an 8-bit approximation.

Software that needs all 10 bits reads the lower byte first and the upper byte second. The lower-byte read arms an interlock, and the upper-byte read releases it. While the interlock is armed, the stored result cannot change, so both halves come from one conversion. A conversion that completes while the interlock is armed is dropped. Reading only the upper byte leaves the interlock alone. This is the usual way to read in left justification.

The interlock is a two-state machine. In `ST_OPEN` the store accepts results. Transition `T_LOCK` is taken on a lower-byte read and leads to `ST_HELD`. In `ST_HELD` the store refuses results. Transition `T_RELEASE` is taken on an upper-byte read and leads back to `ST_OPEN`. A lower-byte read in `ST_HELD` and an upper-byte read in `ST_OPEN` leave the state as it is.

Top module: `conv_result_regs`

## Requirements
- R1: After reset the stored result is zero, the interlock is released (`ST_OPEN`), and `rd_data` is 0x00. A lower-byte read and an upper-byte read made straight after reset both return 0x00.
- R2: When `cvt_done` is high in `ST_OPEN`, and no lower-byte read happens in the same cycle, `cvt_data` is stored at that clock edge and is returned by the reads that follow.
- R3: With `left_just`=0 (right justification): the lower byte is data[7:0]. Bits 1:0 of the upper byte are data[9:8], and bits 7:2 of the upper byte read as 0.
- R4: With `left_just`=1 (left justification): the upper byte is data[9:2]. Bits 7:6 of the lower byte are data[1:0], and bits 5:0 of the lower byte read as 0.
- R5: A lower-byte read (`rd_en`=1, `rd_sel`=0) moves the machine to `ST_HELD`. Any conversion that completes while the machine is in `ST_HELD` is discarded, and it does not appear after release.
- R6: An upper-byte read (`rd_en`=1, `rd_sel`=1) in `ST_HELD` returns to `ST_OPEN`. A later conversion is then stored.
- R7: An upper-byte read in `ST_OPEN` does not arm the interlock: a conversion after it is stored.
- R8: A change of `left_just` applies to the next read at once, with no new conversion needed.
- R9: `rd_data` takes the selected byte at the clock edge where `rd_en` is sampled high, and holds it until the next read.
- R10: A conversion is discarded if it completes in the same cycle as a lower-byte read. It is also discarded if it completes in the same cycle as the upper-byte read that releases the interlock.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| cvt_done | input | 1 | One-cycle strobe marking a completed conversion |
| cvt_data | input | 10 | Result that comes with `cvt_done` |
| left_just | input | 1 | 1 = left justification, 0 = right justification |
| rd_en | input | 1 | One-cycle byte-read strobe |
| rd_sel | input | 1 | Byte select: 0 = lower byte, 1 = upper byte |
| rd_data | output | 8 | Byte returned by the most recent read |

## Verification
`rd_data` changes exactly one rising edge after a cycle with `rd_en` high. A result from `cvt_done` is stored at the same edge, so the earliest read that can return it is one strobed in the next cycle. The interlock state also changes at the edge of the read strobe, so it already governs a conversion in the next cycle. The bench raises every strobe on a falling edge, drops it on the next falling edge, and samples `rd_data` there, one rising edge after the strobe. The cases where a read and a conversion land in the same cycle are driven in one cycle to test R10.

// File: rtl/conv_rd_pkg.sv
package conv_rd_pkg;

    typedef enum logic {
        ST_OPEN = 1'b0,
        ST_HELD = 1'b1
    } lock_state_e;

    typedef enum logic {
        SEL_LO = 1'b0,
        SEL_HI = 1'b1
    } byte_sel_e;

endpackage

// File: rtl/conv_lock_fsm.sv
module conv_lock_fsm
    import conv_rd_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic rd_en,
    input  logic rd_sel,
    output logic held,
    output logic upd_allow
);

    lock_state_e state_q;
    lock_state_e state_d;
    logic        lo_read;
    logic        hi_read;

    assign lo_read = rd_en && (byte_sel_e'(rd_sel) == SEL_LO);
    assign hi_read = rd_en && (byte_sel_e'(rd_sel) == SEL_HI);

    // next state: T_LOCK and T_RELEASE
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_OPEN: if (lo_read) state_d = ST_HELD;   // T_LOCK
            ST_HELD: if (hi_read) state_d = ST_OPEN;   // T_RELEASE
            default: state_d = ST_OPEN;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_OPEN;
        else        state_q <= state_d;
    end

    // outputs
    always_comb begin
        held      = 1'b0;
        upd_allow = 1'b0;
        unique case (state_q)
            ST_OPEN: upd_allow = !lo_read;
            ST_HELD: held      = 1'b1;
            default: upd_allow = 1'b0;
        endcase
    end

    // R5
    lo_read_locks_chk: assert property (@(posedge clk) disable iff (!rst_n)
        lo_read |=> held);
    // R6
    hi_read_releases_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (held && hi_read) |=> !held);
    // R7
    hi_alone_no_lock_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!held && hi_read) |=> !held);

endmodule

// File: rtl/conv_result_store.sv
module conv_result_store #(
    parameter int RES_W = 10
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [RES_W-1:0] wr_data,
    output logic [RES_W-1:0] res_q
);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)     res_q <= '0;
        else if (wr_en) res_q <= wr_data;
    end

endmodule

// File: rtl/conv_byte_format.sv
module conv_byte_format #(
    parameter int RES_W  = 10,
    parameter int BYTE_W = 8
) (
    input  logic [RES_W-1:0]  res,
    input  logic              left_just,
    output logic [BYTE_W-1:0] lo_byte,
    output logic [BYTE_W-1:0] hi_byte
);

    localparam int PAIR_W = 2 * BYTE_W;
    localparam int PAD_W  = PAIR_W - RES_W;

    logic [PAIR_W-1:0] pair_right;
    logic [PAIR_W-1:0] pair_left;
    logic [PAIR_W-1:0] pair;

    generate
        if (PAD_W > 0) begin : g_pad
            assign pair_right = {{PAD_W{1'b0}}, res};
            assign pair_left  = {res, {PAD_W{1'b0}}};
        end else begin : g_full
            assign pair_right = res;
            assign pair_left  = res;
        end
    endgenerate

    assign pair    = left_just ? pair_left : pair_right;
    assign lo_byte = pair[BYTE_W-1:0];
    assign hi_byte = pair[PAIR_W-1:BYTE_W];

endmodule

// File: rtl/conv_result_regs.sv
module conv_result_regs
    import conv_rd_pkg::*;
#(
    parameter int RES_W  = 10,
    parameter int BYTE_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cvt_done,
    input  logic [RES_W-1:0]  cvt_data,
    input  logic              left_just,
    input  logic              rd_en,
    input  logic              rd_sel,
    output logic [BYTE_W-1:0] rd_data
);

    localparam int HI_USED = RES_W - BYTE_W;

    logic              held;
    logic              upd_allow;
    logic              store_wr;
    logic [RES_W-1:0]  res_q;
    logic [BYTE_W-1:0] lo_byte;
    logic [BYTE_W-1:0] hi_byte;

    conv_lock_fsm u_lock (
        .clk       (clk),
        .rst_n     (rst_n),
        .rd_en     (rd_en),
        .rd_sel    (rd_sel),
        .held      (held),
        .upd_allow (upd_allow)
    );

    assign store_wr = cvt_done && upd_allow;

    conv_result_store #(.RES_W(RES_W)) u_store (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (store_wr),
        .wr_data (cvt_data),
        .res_q   (res_q)
    );

    conv_byte_format #(.RES_W(RES_W), .BYTE_W(BYTE_W)) u_fmt (
        .res       (res_q),
        .left_just (left_just),
        .lo_byte   (lo_byte),
        .hi_byte   (hi_byte)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)     rd_data <= '0;
        else if (rd_en) rd_data <= (byte_sel_e'(rd_sel) == SEL_HI) ? hi_byte : lo_byte;
    end

    // R5
    held_freezes_chk: assert property (@(posedge clk) disable iff (!rst_n)
        held |=> $stable(res_q));
    // R2
    open_accepts_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cvt_done && !held && !(rd_en && !rd_sel)) |=> (res_q == $past(cvt_data)));
    // R10
    lo_collide_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && !rd_sel) |=> $stable(res_q));
    // R9
    rd_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_en |=> $stable(rd_data));
    // R3
    right_hi_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && rd_sel && !left_just) |=> ((rd_data >> HI_USED) == '0));

endmodule

// File: tb/sim_conv_result_regs.sv
`timescale 1ns/1ps
module sim_conv_result_regs;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cvt_done = 1'b0;
    logic [9:0] cvt_data = '0;
    logic       left_just = 1'b0;
    logic       rd_en = 1'b0;
    logic       rd_sel = 1'b0;
    logic [7:0] rd_data;

    int n_checks = 0;
    int n_errors = 0;
    logic [7:0] got;

    always #2 clk = ~clk;   // 250 MHz

    conv_result_regs u0 (
        .clk(clk), .rst_n(rst_n), .cvt_done(cvt_done), .cvt_data(cvt_data),
        .left_just(left_just), .rd_en(rd_en), .rd_sel(rd_sel), .rd_data(rd_data)
    );

    function automatic logic [7:0] exp_byte(input logic [9:0] d, input logic lj, input logic hi);
        logic [15:0] p;
        p = lj ? {d, 6'b000000} : {6'b000000, d};
        return hi ? p[15:8] : p[7:0];
    endfunction

    task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_errors++;
            $display("FAIL %s: got 0x%02h expected 0x%02h", req, act, exp);
        end
    endtask

    task automatic convert(input logic [9:0] d);
        @(negedge clk);
        cvt_done = 1'b1; cvt_data = d;
        @(negedge clk);
        cvt_done = 1'b0;
    endtask

    task automatic rd(input logic s, output logic [7:0] v);
        @(negedge clk);
        rd_en = 1'b1; rd_sel = s;
        @(negedge clk);
        rd_en = 1'b0;
        v = rd_data;
    endtask

    task automatic rd_with_cvt(input logic s, input logic [9:0] d, output logic [7:0] v);
        @(negedge clk);
        rd_en = 1'b1; rd_sel = s; cvt_done = 1'b1; cvt_data = d;
        @(negedge clk);
        rd_en = 1'b0; cvt_done = 1'b0;
        v = rd_data;
    endtask

    task automatic t_reset();
        check("R1 rd_data after reset", rd_data, 8'h00);
        rd(1'b0, got); check("R1 lo after reset", got, 8'h00);
        rd(1'b1, got); check("R1 hi after reset", got, 8'h00);
    endtask

    task automatic t_right();
        left_just = 1'b0;
        convert(10'h2B5);
        rd(1'b0, got); check("R2 R3 right lo", got, 8'hB5);
        rd(1'b1, got); check("R3 right hi", got, 8'h02);
        repeat (3) @(negedge clk);
        check("R9 rd_data held", rd_data, 8'h02);
    endtask

    task automatic t_left();
        left_just = 1'b1;
        convert(10'h3C7);
        rd(1'b0, got); check("R4 left lo", got, exp_byte(10'h3C7, 1'b1, 1'b0));
        rd(1'b1, got); check("R4 left hi", got, exp_byte(10'h3C7, 1'b1, 1'b1));
        left_just = 1'b0;
    endtask

    task automatic t_lock();
        convert(10'h155);
        rd(1'b0, got); check("R5 lo before lock", got, 8'h55);
        convert(10'h2AA);
        rd(1'b1, got); check("R5 hi frozen", got, 8'h01);
        rd(1'b0, got); check("R5 dropped not replayed lo", got, 8'h55);
        rd(1'b1, got); check("R5 dropped not replayed hi", got, 8'h01);
    endtask

    task automatic t_release();
        convert(10'h0F3);
        rd(1'b0, got); check("R6 new lo after release", got, 8'hF3);
        rd(1'b1, got); check("R6 new hi after release", got, 8'h00);
    endtask

    task automatic t_hionly();
        left_just = 1'b1;
        convert(10'h1E4);
        rd(1'b1, got); check("R7 hi only first", got, exp_byte(10'h1E4, 1'b1, 1'b1));
        convert(10'h399);
        rd(1'b1, got); check("R7 hi only not locked", got, exp_byte(10'h399, 1'b1, 1'b1));
        left_just = 1'b0;
    endtask

    task automatic t_just_switch();
        left_just = 1'b0;
        convert(10'h36D);
        rd(1'b0, got); check("R8 right lo", got, 8'h6D);
        left_just = 1'b1;
        rd(1'b1, got); check("R8 switched hi", got, exp_byte(10'h36D, 1'b1, 1'b1));
        rd(1'b0, got); check("R8 switched lo", got, exp_byte(10'h36D, 1'b1, 1'b0));
        rd(1'b1, got);
        left_just = 1'b0;
    endtask

    task automatic t_collide();
        left_just = 1'b0;
        convert(10'h1A2);
        rd_with_cvt(1'b0, 10'h25C, got); check("R10 lo with cvt old lo", got, 8'hA2);
        rd(1'b1, got); check("R10 lo with cvt old hi", got, 8'h01);
        rd(1'b0, got); check("R10 relock lo", got, 8'hA2);
        rd_with_cvt(1'b1, 10'h0C3, got); check("R10 release with cvt hi", got, 8'h01);
        rd(1'b0, got); check("R10 release cvt dropped", got, 8'hA2);
        rd(1'b1, got);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        n_checks++; n_errors++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_right();
        t_left();
        t_lock();
        t_release();
        t_hionly();
        t_just_switch();
        t_collide();
        repeat (2) @(negedge clk);
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end

endmodule